// File: doc/BRIEF.md
# Clocked Sequencer for an Asynchronous Byte-Lane SRAM

This block sits between a synchronous host and an asynchronous 16-bit static RAM. The host offers one access at a time on a valid/ready handshake. Each access carries a word address, a write flag, 16 bits of write data and a two-bit lane mask. The sequencer then drives the memory's chip selects, write strobe, output enable, lane enables, address and data bus. It holds each phase for a whole number of clock cycles. Every count comes from a nanosecond figure passed in as a parameter.

A read keeps address, selects and lane enables steady with output enable low. It then captures the bus and returns the word on a one-cycle response pulse. After every read, the sequencer waits for the memory's output-release time before it accepts more work. A write drives the data with output enable held high, and holds the write strobe low for the longest of the strobe-width, address-to-end, lane-to-end and data-setup times. One hold cycle follows, which stretches the access to the write cycle time. The sequencer then lets go of the bus. Between accesses every enable is inactive, so the memory stays in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, and whenever no access is in progress, the chip select outputs are inactive (`sram_ce1_n`=1, `sram_ce2`=0). `sram_we_n`, `sram_oe_n`, `sram_bhe_n` and `sram_ble_n` are all 1, `sram_dq_oe` is 0 and `req_ready` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access and its recovery are complete.
- R3: A read holds the address and selects with `sram_oe_n`=0 and `sram_we_n`=1 for N_RD cycles, then samples the bus. N_RD is the largest cycle count among read cycle, address-to-data, enable-to-data and lane-to-data. The bus is idle for N_HZ cycles before `req_ready` returns. With the defaults (8 ns clock), N_RD=7 and N_HZ=3.
- R4: Mask bit 0 enables the low lane (bits 7:0, `sram_ble_n`=0) and mask bit 1 enables the high lane (bits 15:8, `sram_bhe_n`=0), on reads and on writes alike. A read returns zero in any lane whose mask bit is 0.
- R5: A write holds `sram_we_n`=0 with `sram_oe_n`=1 and the data driven for N_PWE cycles. It then spends N_HOLD cycles with the strobe high and the data still driven. N_PWE covers strobe width, address-to-end, lane-to-end and data setup. N_HOLD is at least 1 and fills up to the write cycle time. The defaults give 6 + 1 cycles.
- R6: A write changes only the lanes enabled in its mask; a mask of 00 leaves the word unchanged.
- R7: The sequencer drives the data bus only while `sram_oe_n` is 1. It does not start driving until N_HZ cycles have passed since `sram_oe_n` last rose, so it never overlaps the memory's drive.
- R8: `rsp_valid` pulses for exactly one cycle per read, N_RD cycles after the accepting edge, and never for a write.
- R9: Each nanosecond figure becomes a cycle count by ceiling division by the clock period, with a floor of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Sequencer can take an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_bhe_n | output | 1 | Active-low high lane enable |
| sram_ble_n | output | 1 | Active-low low lane enable |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_o | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Sequencer drives the data bus |
| sram_dq_i | input | 16 | Data from the memory bus |

## Verification
The embedded properties assume a host that follows the handshake: it keeps its request steady until it sees the accepting edge. They also assume a memory that drives the bus only while output enable is low, plus its release time. The bench holds each request through one rising edge with ready high and drops valid at the next falling edge. Its byte-lane memory model drives lanes only on selected reads. It keeps driving for 20 ns after a deselect and returns garbage until both the address-to-data and enable-to-data times have passed since the last change. Random addresses are confined to sixteen words, so writes and reads fall on the same locations and exercise read-after-write in both directions.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W    = 19,
  parameter int CLK_NS    = 8,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_DOE_NS  = 25,
  parameter int T_DBE_NS  = 55,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 45,
  parameter int T_AW_NS   = 45,
  parameter int T_BW_NS   = 45,
  parameter int T_SD_NS   = 25,
  parameter int T_HZOE_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_bhe_n,
  output logic              sram_ble_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [15:0]       sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [15:0]       sram_dq_i
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R9
  localparam int N_RD   = max2(max2(ns2cyc(T_RC_NS), ns2cyc(T_AA_NS)),
                               max2(ns2cyc(T_DOE_NS), ns2cyc(T_DBE_NS)));
  localparam int N_PWE  = max2(max2(ns2cyc(T_PWE_NS), ns2cyc(T_AW_NS)),
                               max2(ns2cyc(T_BW_NS), ns2cyc(T_SD_NS)));
  localparam int N_WC   = ns2cyc(T_WC_NS);
  localparam int N_HOLD = (N_WC > N_PWE) ? (N_WC - N_PWE) : 1;
  localparam int N_HZ   = ns2cyc(T_HZOE_NS);
  localparam int N_MAX  = max2(max2(N_RD, N_PWE), max2(N_HOLD, N_HZ));
  localparam int CNT_W  = $clog2(N_MAX + 2);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WR, S_HOLD} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic               cnt_done;
  logic               take;

  assign req_ready = (state == S_IDLE);
  assign take      = req_valid && req_ready;
  assign cnt_done  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      sram_ce1_n <= 1'b1;
      sram_ce2   <= 1'b0;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_bhe_n <= 1'b1;
      sram_ble_n <= 1'b1;
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      sram_dq_oe <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (take) begin
          sram_addr  <= req_addr;
          sram_ce1_n <= 1'b0;
          sram_ce2   <= 1'b1;
          sram_ble_n <= ~req_mask[0];
          sram_bhe_n <= ~req_mask[1];
          if (req_write) begin
            sram_we_n  <= 1'b0;
            sram_dq_o  <= req_wdata;
            sram_dq_oe <= 1'b1;
            cnt        <= CNT_W'(N_PWE - 1);
            state      <= S_WR;
          end else begin
            sram_oe_n  <= 1'b0;
            cnt        <= CNT_W'(N_RD - 1);
            state      <= S_RD;
          end
        end
        S_RD: if (cnt_done) begin
          rsp_rdata  <= {sram_bhe_n ? 8'h00 : sram_dq_i[15:8],
                         sram_ble_n ? 8'h00 : sram_dq_i[7:0]};
          rsp_valid  <= 1'b1;
          sram_oe_n  <= 1'b1;
          sram_ce1_n <= 1'b1;
          sram_ce2   <= 1'b0;
          sram_bhe_n <= 1'b1;
          sram_ble_n <= 1'b1;
          cnt        <= CNT_W'(N_HZ - 1);
          state      <= S_TURN;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt_done) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        S_WR: if (cnt_done) begin
          sram_we_n <= 1'b1;
          cnt       <= CNT_W'(N_HOLD - 1);
          state     <= S_HOLD;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (cnt_done) begin
          sram_dq_oe <= 1'b0;
          sram_ce1_n <= 1'b1;
          sram_ce2   <= 1'b0;
          sram_bhe_n <= 1'b1;
          sram_ble_n <= 1'b1;
          state      <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W:0] since_oe_hi;
  logic [CNT_W:0] we_low_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_oe_hi <= (CNT_W+1)'(N_HZ + 1);
      we_low_cyc  <= '0;
    end else begin
      if (!sram_oe_n) since_oe_hi <= '0;
      else if (since_oe_hi < (CNT_W+1)'(N_HZ + 1)) since_oe_hi <= since_oe_hi + 1'b1;
      if (!sram_we_n) begin
        if (we_low_cyc < (CNT_W+1)'(N_PWE + 1)) we_low_cyc <= we_low_cyc + 1'b1;
      end else we_low_cyc <= '0;
    end
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);

  // R3
  rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && $past(!sram_oe_n)) |-> ($stable(sram_addr) && !sram_ce1_n && sram_we_n));

  // R5
  we_with_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && sram_dq_oe && !sram_ce1_n && sram_ce2));

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_cyc >= (CNT_W+1)'(N_PWE)));

  // R7
  drive_oe_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (since_oe_hi >= (CNT_W+1)'(N_HZ)));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!sram_oe_n));

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/100ps
module tb_sram_async_ctrl;
  localparam int AW     = 8;
  localparam int CLK_NS = 8;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD   = mx(mx(cyc(55), cyc(55)), mx(cyc(25), cyc(55)));
  localparam int E_PWE  = mx(mx(cyc(45), cyc(45)), mx(cyc(45), cyc(25)));
  localparam int E_HOLD = (cyc(55) > E_PWE) ? cyc(55) - E_PWE : 1;
  localparam int E_HZ   = cyc(20);

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic [1:0]    req_mask;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic          sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_bhe_n, sram_ble_n;
  logic [AW-1:0] sram_addr;
  logic [15:0]   sram_dq_o, sram_dq_i;
  logic          sram_dq_oe;

  sram_async_ctrl #(.ADDR_W(AW), .CLK_NS(CLK_NS)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_bhe_n(sram_bhe_n), .sram_ble_n(sram_ble_n),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, clash = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // byte-lane memory model
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  realtime t_sel = 0, t_oe_fall = 0, t_we_fall = 0, t_dat = 0;
  int hold_lo = 0, hold_hi = 0;
  logic drv_lo = 0, drv_hi = 0;
  logic [15:0] m_q = '0;

  always @(sram_addr or sram_ce1_n or sram_ce2 or sram_bhe_n or sram_ble_n) t_sel = $realtime;
  always @(negedge sram_oe_n) t_oe_fall = $realtime;
  always @(negedge sram_we_n) t_we_fall = $realtime;
  always @(sram_dq_o or sram_dq_oe) t_dat = $realtime;

  initial begin
    #0.5;
    forever begin
      logic rd;
      rd = !sram_ce1_n && sram_ce2 && sram_we_n && !sram_oe_n;
      if (rd && !sram_ble_n) hold_lo = 20; else if (hold_lo > 0) hold_lo--;
      if (rd && !sram_bhe_n) hold_hi = 20; else if (hold_hi > 0) hold_hi--;
      drv_lo = (rd && !sram_ble_n) || hold_lo > 0;
      drv_hi = (rd && !sram_bhe_n) || hold_hi > 0;
      if (($realtime - t_sel >= 55.0) && ($realtime - t_oe_fall >= 25.0)) m_q = mem[sram_addr];
      else m_q = 16'hBAD0;
      if (sram_dq_oe && (drv_lo || drv_hi)) clash++;
      #1;
    end
  end

  assign sram_dq_i = {drv_hi ? m_q[15:8] : 8'h00, drv_lo ? m_q[7:0] : 8'h00};

  always @(posedge sram_we_n) begin
    if (!sram_ce1_n && sram_ce2) begin
      check($realtime - t_we_fall >= 45.0, "R5 strobe width ns", 32'($rtoi($realtime - t_we_fall)), 32'd45);
      check(sram_dq_oe && ($realtime - t_dat >= 25.0), "R5 data setup ns", 32'($rtoi($realtime - t_dat)), 32'd25);
      if (!sram_ble_n) mem[sram_addr][7:0]  = sram_dq_o[7:0];
      if (!sram_bhe_n) mem[sram_addr][15:8] = sram_dq_o[15:8];
    end
  end

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
  endfunction
  function automatic logic [15:0] lanes(input logic [15:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic idle_check(input string req);
    check(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && sram_bhe_n && sram_ble_n
          && !sram_dq_oe && req_ready, req,
          {26'd0, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe, req_ready},
          {26'd0, 6'b101101});
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
    int k, got, lat;
    bit oe_ok;
    logic [15:0] rd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R2 ready low after take", {31'd0, req_ready}, 32'd0);
    check({sram_bhe_n, sram_ble_n} == ~m, "R4 lane enables", {30'd0, sram_bhe_n, sram_ble_n}, {30'd0, ~m});
    k = 0; got = 0; lat = -1; oe_ok = 1; rd = '0;
    while (!req_ready && k < 100) begin
      if (rsp_valid) begin got++; lat = k; rd = rsp_rdata; end
      if (wr && !sram_oe_n) oe_ok = 0;
      k++;
      @(negedge clk);
    end
    if (wr) begin
      check(k == E_PWE + E_HOLD, "R5 R9 write busy cycles", k, E_PWE + E_HOLD);
      check(got == 0, "R8 no response on write", got, 0);
      check(oe_ok, "R5 output enable high on write", {31'd0, oe_ok}, 32'd1);
      shadow[a] = merge(shadow[a], d, m);
    end else begin
      check(k == E_RD + E_HZ, "R3 R9 read busy cycles", k, E_RD + E_HZ);
      check(got == 1 && lat == E_RD, "R8 R3 response latency", lat, E_RD);
      check(rd == lanes(shadow[a], m), "R4 R6 read data", rd, lanes(shadow[a], m));
    end
    idle_check("R1 idle after access");
  endtask

  task automatic finish_run();
    check(clash == 0, "R7 bus overlap ticks", clash, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual busy expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      shadow[i] = mem[i];
    end
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_mask = '0;
    seed = $urandom(32'hC0FFEE);
    repeat (5) @(negedge clk);
    idle_check("R1 reset state");
    rst_n = 1;
    @(negedge clk);
    idle_check("R1 after reset release");

    access(1, 8'd3, 16'h1234, 2'b11);
    access(0, 8'd3, 16'h0000, 2'b11);
    access(1, 8'd3, 16'hFFEE, 2'b10);
    access(0, 8'd3, 16'h0000, 2'b01);
    access(0, 8'd3, 16'h0000, 2'b10);
    access(1, 8'd3, 16'hAAAA, 2'b00);
    access(0, 8'd3, 16'h0000, 2'b11);
    check(shadow[3] == 16'hFF34, "R6 directed merge", shadow[3], 16'hFF34);
    access(0, 8'd3, 16'h0000, 2'b00);
    access(0, 8'd200, 16'h0000, 2'b11);
    access(1, 8'd200, 16'h00C5, 2'b01);
    access(0, 8'd200, 16'h0000, 2'b11);

    for (int n = 0; n < 300; n++) begin
      access(1'($urandom % 2), AW'($urandom % 16), 16'($urandom), 2'($urandom % 4));
    end

    done = 1;
    finish_run();
  end
endmodule